// File: doc/BRIEF.md
# Byte-Wide RAM with Overlaid Clock Registers

This block presents a byte-wide static-RAM style interface, modelled on a synchronous system clock. Behind it sits a storage array whose eight highest addresses are replaced by a bank of real-time-clock registers. The interface has an active-low select, an active-low output enable and an active-low write strobe. A power-good input blocks all traffic while it is low. The address width is a parameter: a full 8K-byte part uses 13 bits, and the default build uses 11 bits (2K bytes) to keep elaboration light.

The running time is kept by a separate counter block. That block feeds this one the current time and a 1 Hz tick, and it accepts a load strobe with new values. This block keeps a user-visible copy of the time apart from those counters. With no halt requested, the copy is refreshed atomically on each tick. A read-halt bit in the control register freezes the copy so that software sees a consistent snapshot while counting goes on. A write-halt bit lets software stage a new time in the copy. Clearing the write-halt bit commits the staged time to the counters with a single load strobe.

Top module: `rtc_sram_bank`

## Requirements
- R1: Address offsets 0 to 7 above BASE = 2^ADDR_W - 8 select, in order, control, seconds, minutes, hours, day, date, month and year. Every address below BASE is plain RAM.
- R2: A read cycle is select low, write strobe high and power-good high. A read cycle with output enable low makes bus_drive 1 in the next cycle, with bus_rdata holding the addressed byte. In every other case bus_drive is 0 in the next cycle and bus_rdata is 0.
- R3: A write cycle is select low, write strobe low and power-good high. A write cycle below BASE stores bus_wdata, and a later read returns it.
- R4: In the control register, bit 7 is the write-halt bit and bit 6 is the read-halt bit. Bits 5:0 are plain storage. All eight bits read back as written.
- R5: When neither halt bit is set, a cnt_tick copies the time fields of all seven clock registers at one edge. Register offset k takes cnt_time[8k-1:8k-8], and its non-time bits are left unchanged.
- R6: While the read-halt bit is 1, the visible time fields do not change on ticks.
- R7: A control write that clears both halt bits when only the read-halt bit was set copies cnt_time into the visible time fields at that same edge.
- R8: The time-field masks are 7F (seconds), 7F (minutes), 3F (hours), 07 (day), 3F (date), 1F (month) and FF (year). Time-field bits are written only while the write-halt bit is 1, and otherwise the written value is ignored. The remaining bits are always writable.
- R9: A control write that changes the write-halt bit from 1 to 0 raises load_stb for exactly the next cycle. In that cycle load_time carries the visible time fields, packed as in R5, with non-time bits 0.
- R10: While power-good is low, no access takes effect: no bus drive, no RAM or register write, and no load strobe.
- R11: After reset the control register and all clock registers read 0, and bus_drive and load_stb are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous active-high reset |
| pwr_ok | input | 1 | supply good; low blocks every access |
| sel_n | input | 1 | chip select, active low |
| oe_n | input | 1 | output enable, active low |
| wr_n | input | 1 | write strobe, active low |
| bus_addr | input | ADDR_W | byte address |
| bus_wdata | input | 8 | write data |
| bus_rdata | output | 8 | registered read data, 0 when not driven |
| bus_drive | output | 1 | read data valid and driven this cycle |
| cnt_tick | input | 1 | one-cycle 1 Hz tick from the counter block |
| cnt_time | input | 56 | running time, one byte per clock register |
| load_stb | output | 1 | one-cycle strobe to load the counters |
| load_time | output | 56 | time to load, same packing as cnt_time |

## Verification
The assertions assume that cnt_tick, cnt_time and the bus inputs change only between clock edges. They also assume that the tick input is held low during reset, so that the refresh check never sees a tick that reset has swallowed. The stimulus drives every input on the falling edge. It keeps the tick low until reset is released, and it acts as the counter block by adopting load_time whenever load_stb is seen. RAM reads are drawn only from addresses the bench has already written, so every read has a defined expected value.

// File: rtl/rtc_bank_pkg.sv
package rtc_bank_pkg;
  localparam int NTIME  = 7;
  localparam int TIME_W = NTIME * 8;
  localparam int WBIT   = 7;
  localparam int RBIT   = 6;

  typedef enum logic [2:0] {
    OFS_CTRL, OFS_SEC, OFS_MIN, OFS_HOUR, OFS_DAY, OFS_DATE, OFS_MONTH, OFS_YEAR
  } reg_ofs_e;

  // Time-field mask of clock register k (k = 0 is seconds, k = 6 is year).
  function automatic logic [7:0] time_mask(input int unsigned k);
    case (k)
      0, 1:    return 8'h7F;
      2, 4:    return 8'h3F;
      3:       return 8'h07;
      5:       return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  // Clears every non-time bit of a packed seven-byte time word.
  function automatic logic [TIME_W-1:0] mask_time(input logic [TIME_W-1:0] v);
    logic [TIME_W-1:0] r;
    for (int k = 0; k < NTIME; k++) r[8*k +: 8] = v[8*k +: 8] & time_mask(k);
    return r;
  endfunction
endpackage

// File: rtl/rtc_addr_decode.sv
module rtc_addr_decode #(
  parameter int ADDR_W = 11
) (
  input  logic              pwr_ok,
  input  logic              sel_n,
  input  logic              oe_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              acc_wr,
  output logic              drive_req,
  output logic              hit_clk,
  output logic [2:0]        reg_idx
);
  logic live;

  assign live      = pwr_ok && !sel_n;
  assign acc_wr    = live && !wr_n;
  assign drive_req = live && wr_n && !oe_n;
  assign hit_clk   = &addr[ADDR_W-1:3];
  assign reg_idx   = addr[2:0];
endmodule

// File: rtl/rtc_ram_array.sv
module rtc_ram_array #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/rtc_shadow_regs.sv
module rtc_shadow_regs
  import rtc_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        reg_idx,
  input  logic [7:0]        wdata,
  input  logic              tick,
  input  logic [TIME_W-1:0] cnt_time,
  output logic [7:0]        rd_byte,
  output logic [TIME_W-1:0] vis_time,
  output logic              wbit_q,
  output logic              rbit_q,
  output logic              halted,
  output logic              load_stb,
  output logic [TIME_W-1:0] load_time
);
  logic [5:0]        spare_q;
  logic [TIME_W-1:0] vis_raw;
  logic              ctrl_wr, new_halt, resume_evt, refresh_evt, commit_evt;

  assign halted      = wbit_q | rbit_q;
  assign ctrl_wr     = wr_en && (reg_idx == 3'(OFS_CTRL));
  assign new_halt    = wdata[WBIT] | wdata[RBIT];
  assign resume_evt  = ctrl_wr && rbit_q && !wbit_q && !new_halt;
  assign refresh_evt = (tick && !halted) || resume_evt;
  assign commit_evt  = ctrl_wr && wbit_q && !wdata[WBIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      wbit_q    <= 1'b0;
      rbit_q    <= 1'b0;
      spare_q   <= '0;
      load_stb  <= 1'b0;
      load_time <= '0;
    end else begin
      load_stb <= commit_evt;
      if (commit_evt) load_time <= vis_time;
      if (ctrl_wr) begin
        wbit_q  <= wdata[WBIT];
        rbit_q  <= wdata[RBIT];
        spare_q <= wdata[5:0];
      end
    end
  end

  for (genvar g = 0; g < NTIME; g++) begin : g_reg
    localparam logic [7:0] MASK = time_mask(g);
    logic       hit;
    logic [7:0] val_q, nxt;

    assign hit = wr_en && (reg_idx == 3'(g + 1));

    always_comb begin
      nxt = val_q;
      if (hit)           nxt = (nxt & MASK) | (wdata & ~MASK);
      if (hit && wbit_q) nxt = (nxt & ~MASK) | (wdata & MASK);
      if (refresh_evt)   nxt = (nxt & ~MASK) | (cnt_time[8*g +: 8] & MASK);
    end

    always_ff @(posedge clk) begin
      if (rst) val_q <= '0;
      else     val_q <= nxt;
    end

    assign vis_raw[8*g +: 8]  = val_q;
    assign vis_time[8*g +: 8] = val_q & MASK;
  end

  always_comb begin
    rd_byte = {wbit_q, rbit_q, spare_q};
    for (int j = 0; j < NTIME; j++)
      if (reg_idx == 3'(j + 1)) rd_byte = vis_raw[8*j +: 8];
  end
endmodule

// File: rtl/rtc_sram_bank.sv
module rtc_sram_bank
  import rtc_bank_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_ok,
  input  logic              sel_n,
  input  logic              oe_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              bus_drive,
  input  logic              cnt_tick,
  input  logic [TIME_W-1:0] cnt_time,
  output logic              load_stb,
  output logic [TIME_W-1:0] load_time
);
  logic              acc_wr, drive_req, hit_clk;
  logic [2:0]        reg_idx;
  logic [7:0]        ram_q, clk_byte, clk_q;
  logic              drive_q, hit_q;
  logic              wbit_w, rbit_w, halted_w;
  logic [TIME_W-1:0] vis_time_w;

  rtc_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .pwr_ok(pwr_ok), .sel_n(sel_n), .oe_n(oe_n), .wr_n(wr_n), .addr(bus_addr),
    .acc_wr(acc_wr), .drive_req(drive_req), .hit_clk(hit_clk), .reg_idx(reg_idx)
  );

  rtc_ram_array #(.AW(ADDR_W), .DW(8)) u_ram (
    .clk(clk), .we(acc_wr && !hit_clk), .addr(bus_addr), .wdata(bus_wdata), .rdata(ram_q)
  );

  rtc_shadow_regs u_shadow (
    .clk(clk), .rst(rst), .wr_en(acc_wr && hit_clk), .reg_idx(reg_idx),
    .wdata(bus_wdata), .tick(cnt_tick), .cnt_time(cnt_time), .rd_byte(clk_byte),
    .vis_time(vis_time_w), .wbit_q(wbit_w), .rbit_q(rbit_w), .halted(halted_w),
    .load_stb(load_stb), .load_time(load_time)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_q <= 1'b0;
      hit_q   <= 1'b0;
      clk_q   <= '0;
    end else begin
      drive_q <= drive_req;
      hit_q   <= hit_clk;
      clk_q   <= clk_byte;
    end
  end

  assign bus_drive = drive_q;
  assign bus_rdata = drive_q ? (hit_q ? clk_q : ram_q) : 8'h00;
endmodule

// File: rtl/rtc_sram_bank_chk.sv
module rtc_sram_bank_chk
  import rtc_bank_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              pwr_ok,
  input logic              sel_n,
  input logic              oe_n,
  input logic              wr_n,
  input logic              cnt_tick,
  input logic [TIME_W-1:0] cnt_time,
  input logic              bus_drive,
  input logic              load_stb,
  input logic              wbit_w,
  input logic              rbit_w,
  input logic              halted_w,
  input logic [TIME_W-1:0] vis_time_w
);
  logic [TIME_W-1:0] cnt_m;
  assign cnt_m = mask_time(cnt_time);

  // R2: drive only after an enabled read cycle
  a_r2_drive_needs_read: assert property (@(posedge clk) disable iff (rst)
    bus_drive |-> $past(pwr_ok && !sel_n && !oe_n && wr_n));

  // R9: load strobe only when the write-halt bit has just cleared
  a_r9_load_on_wbit_clear: assert property (@(posedge clk) disable iff (rst)
    load_stb |-> ($past(wbit_w) && !wbit_w));

  // R6: visible time frozen while the read-halt bit holds
  a_r6_read_halt_freezes: assert property (@(posedge clk) disable iff (rst)
    (rbit_w && $past(rbit_w) && !$past(wbit_w)) |-> $stable(vis_time_w));

  // R10: nothing happens without power-good
  a_r10_power_blocks: assert property (@(posedge clk) disable iff (rst)
    !$past(pwr_ok) |-> (!bus_drive && !load_stb));

  // R5: unhalted tick copies the counters
  a_r5_tick_refresh: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(cnt_tick && !halted_w)) |-> (vis_time_w == $past(cnt_m)));
endmodule

bind rtc_sram_bank rtc_sram_bank_chk u_chk (
  .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .sel_n(sel_n), .oe_n(oe_n), .wr_n(wr_n),
  .cnt_tick(cnt_tick), .cnt_time(cnt_time), .bus_drive(bus_drive), .load_stb(load_stb),
  .wbit_w(wbit_w), .rbit_w(rbit_w), .halted_w(halted_w), .vis_time_w(vis_time_w)
);

// File: tb/rtc_sram_bank_test.sv
module rtc_sram_bank_test;
  localparam int AW   = 11;
  localparam int BASE = (1 << AW) - 8;
  localparam logic [7:0] BM [7] = '{8'h7F, 8'h7F, 8'h3F, 8'h07, 8'h3F, 8'h1F, 8'hFF};

  logic          clk = 1'b0, rst = 1'b1;
  logic          pwr_ok = 1'b1, sel_n = 1'b1, oe_n = 1'b1, wr_n = 1'b1, cnt_tick = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0]    bus_wdata = '0, bus_rdata;
  logic          bus_drive, load_stb;
  logic [55:0]   cnt_time = '0, load_time;

  rtc_sram_bank #(.ADDR_W(AW)) uut (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [7:0]  m_ram [1 << AW];
  logic [7:0]  m_vis [7];
  logic        m_w = 0, m_r = 0;
  logic [5:0]  m_sp = '0;
  logic [55:0] ctr = '0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_read(input int a);
    if (a < BASE) return m_ram[a];
    if (a == BASE) return {m_w, m_r, m_sp};
    return m_vis[a - BASE - 1];
  endfunction

  task automatic step(input bit pw, input bit sel, input bit oe, input bit we,
                      input int a, input logic [7:0] d, input bit tk, input string tag);
    bit rd, wr, hold, resume, refr, e_drv, e_ld;
    logic [7:0] e_data, t;
    logic [55:0] e_lt;
    string dtag;
    @(negedge clk);
    pwr_ok = pw; sel_n = !sel; oe_n = !oe; wr_n = !we;
    bus_addr = AW'(a); bus_wdata = d; cnt_tick = tk; cnt_time = ctr;
    rd = pw && sel && !we;
    wr = pw && sel && we;
    e_drv  = rd && oe;
    e_data = e_drv ? m_read(a) : 8'h00;
    hold = m_w | m_r;
    e_ld = 0; e_lt = '0; resume = 0;
    if (wr && a == BASE) begin
      if (m_w && !d[7]) begin
        e_ld = 1;
        for (int j = 0; j < 7; j++) e_lt[8*j +: 8] = m_vis[j] & BM[j];
      end
      resume = m_r && !m_w && !d[7] && !d[6];
    end
    refr = (tk && !hold) || resume;
    for (int j = 0; j < 7; j++) begin
      t = m_vis[j];
      if (wr && a == BASE + 1 + j) begin
        t = (t & BM[j]) | (d & ~BM[j]);
        if (m_w) t = (t & ~BM[j]) | (d & BM[j]);
      end
      if (refr) t = (t & ~BM[j]) | (ctr[8*j +: 8] & BM[j]);
      m_vis[j] = t;
    end
    if (wr && a == BASE) begin m_w = d[7]; m_r = d[6]; m_sp = d[5:0]; end
    if (wr && a < BASE) m_ram[a] = d;
    @(posedge clk); #1;
    dtag = (tag != "") ? tag : ((a < BASE) ? "R3" : "R1");
    chk("R2", {63'd0, bus_drive}, {63'd0, e_drv});
    chk(dtag, {56'd0, bus_rdata}, {56'd0, e_data});
    chk("R9", {63'd0, load_stb}, {63'd0, e_ld});
    if (e_ld) begin
      chk("R9", {8'd0, load_time}, {8'd0, e_lt});
      ctr = load_time;
    end
  endtask

  task automatic rd(input int a, input string tag);
    step(1, 1, 1, 0, a, 8'h00, 0, tag);
  endtask
  task automatic wr(input int a, input logic [7:0] d, input string tag);
    step(1, 1, 0, 1, a, d, 0, tag);
  endtask
  task automatic tick(input logic [55:0] v);
    ctr = v;
    step(1, 1, 1, 1, 0, 8'h00, 1, "R5");
    ctr = v;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int j = 0; j < 7; j++) m_vis[j] = 8'h00;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R11 reset state
    rd(BASE, "R11");
    rd(BASE + 1, "R11");
    rd(BASE + 7, "R11");
    // preload RAM
    for (int i = 0; i < 16; i++) wr(i, 8'(i * 37 + 5), "R3");
    for (int i = 1; i <= 8; i++) wr(BASE - i, 8'(i * 11), "R3");
    rd(3, "R3");
    rd(BASE - 1, "R1");
    // R8: time bits ignored without write-halt, spare bit kept
    wr(BASE + 1, 8'hC5, "R8");
    rd(BASE + 1, "R8");
    // R5 tick refresh keeps spare bit
    tick(56'h99_12_31_07_23_59_58);
    rd(BASE + 1, "R5");
    rd(BASE + 7, "R5");
    // R4 control spare bits
    wr(BASE, 8'h2A, "R4");
    rd(BASE, "R4");
    // R6 read halt freezes
    wr(BASE, 8'h40, "R6");
    tick(56'h00_01_01_01_00_00_01);
    rd(BASE + 2, "R6");
    rd(BASE + 6, "R6");
    // R7 resume refresh at clear
    wr(BASE, 8'h00, "R7");
    rd(BASE + 2, "R7");
    rd(BASE + 6, "R7");
    // R8/R9 write halt stage then commit
    wr(BASE, 8'h80, "R4");
    wr(BASE + 3, 8'h23, "R8");
    wr(BASE + 4, 8'hF5, "R8");
    rd(BASE + 3, "R8");
    tick(56'h11_11_11_01_11_11_11);
    rd(BASE + 3, "R8");
    wr(BASE, 8'h00, "R9");
    rd(BASE + 4, "R9");
    // R10 power-good low blocks everything
    step(0, 1, 0, 1, 5, 8'hEE, 0, "R10");
    step(0, 1, 1, 0, 5, 8'h00, 0, "R10");
    wr(BASE, 8'h80, "R10");
    step(0, 1, 0, 1, BASE, 8'h00, 0, "R10");
    rd(BASE, "R10");
    rd(5, "R10");
    wr(BASE, 8'h00, "R9");
    // R2 no drive without output enable or on write
    step(1, 1, 0, 0, 7, 8'h00, 0, "R2");
    step(1, 0, 1, 0, 7, 8'h00, 0, "R2");

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      bit pw, sel, oe, we, tk;
      int a;
      pw  = ($urandom % 10) != 0;
      sel = ($urandom % 10) != 0;
      oe  = ($urandom % 5) != 0;
      we  = ($urandom % 5) < 2;
      tk  = ($urandom % 5) == 0;
      if (tk) ctr = {$urandom, $urandom};
      case ($urandom % 4)
        0:       a = $urandom % 16;
        1:       a = BASE - 1 - ($urandom % 8);
        default: a = BASE + ($urandom % 8);
      endcase
      step(pw, sel, oe, we, a, 8'($urandom), tk, "");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule